// File: doc/BRIEF.md
# Multi-Channel PWM DAC Bank

This block drives fourteen pulse-width-modulated outputs. An external RC filter turns each output into an analog level. All channels share one step counter and one clock-enable prescaler, so every output has the same period and phase. Each channel has its own 8-bit duty code, and its output is high while the shared step count is below that code.

Software writes duty codes through a small register bus with one address per channel. A written code reads back at once. The comparator uses it only from the next period boundary, so no shortened or stretched pulse appears mid-period.

Two static mode inputs shape the waveform:
- One selects the step rate. The fast setting halves the prescaler divide ratio, which doubles the PWM frequency.
- The other selects the period length: 256 steps or 253 steps. In the 253-step mode the top three codes give a constant high level. In the 256-step mode even the largest code leaves one low step per period.

Top module: `pwm_dac_bank`

## Requirements
- R1: After reset every duty register reads 80h, and every output is high for 128 of each 256 steps (mid-scale).
- R2: Bus address 0 to 13 maps to channel 0 to 13 in order. A write with select and write-enable high updates that channel's register, and a read with select high returns it. Addresses 14 and 15 read 00h, and writes to them change no channel.
- R3: Each output is high while the shared step counter is below the channel's active code. In each period the output is high for exactly code steps.
- R4: Code 00h holds the output low for the whole period in both period modes.
- R5: With `step253` high the period is 253 steps (counter 0 to 252). Codes FDh, FEh and FFh give an output that never goes low. Code FCh gives 252 high steps.
- R6: With `step253` low the period is 256 steps (counter 0 to 255). Code FFh gives 255 high steps and exactly one low step per period.
- R7: With `freq_fast` low a step lasts SLOW_DIV clocks (default 4). With `freq_fast` high it lasts SLOW_DIV/2 clocks. The period at default is therefore 1024, 512, 1012 or 506 clocks.
- R8: A written code reads back at once but drives its output only from the next period boundary. The pulse in progress keeps the old width.
- R9: Channels are independent. Writing one channel changes no other channel's output or readback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | ADDR_W (4) | Channel index |
| bus_wdata | input | 8 | Duty code to write |
| bus_rdata | output | 8 | Read data (combinational, 00h when not selected or out of range) |
| freq_fast | input | 1 | 1: halve the prescaler divide ratio |
| step253 | input | 1 | 1: 253-step period, 0: 256-step period |
| pwm_out | output | NUM_CH (14) | Registered PWM outputs, bit i is channel i |

## Verification
The duty comparison is measured as high-clock counts over one full period, using these codes:
- Small, middle and large codes, which tell a correct less-than compare apart from an off-by-one or a less-or-equal compare.
- Zero and the top codes in both period modes, which separate the steady-low, steady-high and single-low-step endings.
- Rising-edge-to-rising-edge spacing in all four frequency and period combinations, which separates the prescaler ratio from the counter wrap point.
- A code cut to 01h just after a period starts, with the output required to stay high, which shows whether the code change waits for the period boundary or lands at once.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;
  localparam int DUTY_W = 8;
  typedef logic [DUTY_W-1:0] duty_t;
  localparam duty_t CODE_AT_RESET = 8'h80;
  localparam duty_t LAST_STEP_LONG = 8'd255;
  localparam duty_t LAST_STEP_SHORT = 8'd252;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_out = out_q;
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int SLOW_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  output logic tick
);
  localparam int FAST_DIV = SLOW_DIV / 2;
  localparam int CW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] limit;

  always_comb begin
    limit = fast ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);
    // Use >= so a switch to the shorter ratio never strands the count.
    tick  = (cnt_q >= limit);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwm_step_ctr.sv
module pwm_step_ctr
  import pwm_dac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  short_mode,
  output duty_t step,
  output logic  wrap
);
  duty_t step_q;
  duty_t step_d;
  duty_t last;
  logic  at_end;

  always_comb begin
    last   = short_mode ? LAST_STEP_SHORT : LAST_STEP_LONG;
    // A count past the end after a mode change also wraps.
    at_end = (step_q >= last);
    wrap   = tick && at_end;
    step_d = step_q;
    if (tick) step_d = at_end ? '0 : step_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  assign step = step_q;
endmodule

// File: rtl/pwm_duty_bank.sv
module pwm_duty_bank
  import pwm_dac_pkg::*;
#(
  parameter int NUM_CH = 14,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  duty_t                    wdata,
  output duty_t                    rdata,
  input  logic                     load,
  output logic [NUM_CH*DUTY_W-1:0] active_flat
);
  duty_t stored [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic  hit;
    duty_t stored_d;
    duty_t active_d;
    duty_t stored_q;
    duty_t active_q;

    always_comb begin
      hit      = sel && we && (int'(addr) == g);
      stored_d = hit ? wdata : stored_q;
      // The comparator copy moves only at the period boundary.
      active_d = load ? stored_q : active_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stored_q <= CODE_AT_RESET;
        active_q <= CODE_AT_RESET;
      end else begin
        stored_q <= stored_d;
        active_q <= active_d;
      end
    end

    assign stored[g] = stored_q;
    assign active_flat[g*DUTY_W +: DUTY_W] = active_q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel && int'(addr) == i) rdata = stored[i];
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_dac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  duty_t step,
  input  duty_t code,
  output logic  pwm
);
  logic pwm_d;
  logic pwm_q;

  always_comb pwm_d = (step < code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

  assign pwm = pwm_q;
endmodule

// File: rtl/pwm_dac_bank.sv
module pwm_dac_bank
  import pwm_dac_pkg::*;
#(
  parameter int NUM_CH   = 14,
  parameter int SLOW_DIV = 4,
  parameter int ADDR_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              freq_fast,
  input  logic              step253,
  output logic [NUM_CH-1:0] pwm_out
);
  logic                     rst_n_sync;
  logic                     tick;
  logic                     wrap;
  duty_t                    step;
  logic [NUM_CH*DUTY_W-1:0] active_flat;

  pwm_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  pwm_prescaler #(.SLOW_DIV(SLOW_DIV)) u_pre (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .fast  (freq_fast),
    .tick  (tick)
  );

  pwm_step_ctr u_ctr (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .tick       (tick),
    .short_mode (step253),
    .step       (step),
    .wrap       (wrap)
  );

  pwm_duty_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .sel         (bus_sel),
    .we          (bus_we),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .rdata       (bus_rdata),
    .load        (wrap),
    .active_flat (active_flat)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_out
    pwm_channel u_ch (
      .clk   (clk),
      .rst_n (rst_n_sync),
      .step  (step),
      .code  (active_flat[g*DUTY_W +: DUTY_W]),
      .pwm   (pwm_out[g])
    );
  end
endmodule

// File: rtl/pwm_dac_bank_chk.sv
module pwm_dac_bank_chk #(
  parameter int NUM_CH = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic                wrap,
  input logic [7:0]          step,
  input logic                step253,
  input logic [NUM_CH*8-1:0] active_flat,
  input logic [NUM_CH-1:0]   pwm_out
);
  assert_ff_low_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step253 && step == 8'hFF) |=> (pwm_out == '0));

  assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(active_flat));

  assert_short_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && step253) |=> (step <= 8'd252));

  assert_tick_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    assert_zero_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active_flat[g*8 +: 8] == 8'h00) |=> !pwm_out[g]);

    assert_top_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step253 && active_flat[g*8 +: 8] >= 8'd253 && step <= 8'd252) |=> pwm_out[g]);
  end
endmodule

bind pwm_dac_bank pwm_dac_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .tick        (tick),
  .wrap        (wrap),
  .step        (step),
  .step253     (step253),
  .active_flat (active_flat),
  .pwm_out     (pwm_out)
);

// File: tb/pwm_dac_bank_bench.sv
module pwm_dac_bank_bench;
  localparam int NCH = 14;
  localparam int DIV = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_sel = 1'b0;
  logic            bus_we = 1'b0;
  logic [3:0]      bus_addr = '0;
  logic [7:0]      bus_wdata = '0;
  logic [7:0]      bus_rdata;
  logic            freq_fast = 1'b0;
  logic            step253 = 1'b0;
  logic [NCH-1:0]  pwm_out;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pwm_dac_bank #(.NUM_CH(NCH), .SLOW_DIV(DIV)) u_pwm_dac_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .freq_fast (freq_fast),
    .step253   (step253),
    .pwm_out   (pwm_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input int ch, input int data);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1;
    bus_addr = 4'(ch); bus_wdata = 8'(data);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input int ch, output int data);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 4'(ch);
    #1 data = int'(bus_rdata);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic high_count(input int ch, input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out[ch]) cnt++;
    end
  endtask

  // Clocks between two rising edges of a channel.
  task automatic period_of(input int ch, output int clks);
    clks = 0;
    @(negedge clk);
    while (pwm_out[ch]) @(negedge clk);
    while (!pwm_out[ch]) @(negedge clk);
    do begin
      @(negedge clk);
      clks++;
    end while (pwm_out[ch]);
    while (!pwm_out[ch]) begin
      @(negedge clk);
      clks++;
    end
  endtask

  // Apply a code, let it reach the comparator, then count highs over one period.
  task automatic duty_check(input int ch, input int code, input int period,
                            input int expect_hi, input string req);
    int hi;
    bus_write(ch, code);
    wait_clks(2 * period);
    high_count(ch, period, hi);
    check(hi == expect_hi, req, $sformatf("ch%0d code %0h high clocks", ch, code),
          hi, expect_hi);
  endtask

  task automatic t_reset;
    int v;
    int hi;
    for (int c = 0; c < NCH; c++) begin
      bus_read(c, v);
      check(v == 8'h80, "R1", $sformatf("reset value ch%0d", c), v, 8'h80);
    end
    wait_clks(64);
    high_count(7, 256 * DIV, hi);
    check(hi == 128 * DIV, "R1", "mid-scale high clocks", hi, 128 * DIV);
  endtask

  task automatic t_bus;
    int v;
    for (int c = 0; c < NCH; c++) bus_write(c, c * 17 + 1);
    for (int c = 0; c < NCH; c++) begin
      bus_read(c, v);
      check(v == c * 17 + 1, "R2", $sformatf("readback ch%0d", c), v, c * 17 + 1);
    end
    bus_write(14, 8'h5A);
    bus_write(15, 8'hA5);
    bus_read(14, v);
    check(v == 0, "R2", "unmapped addr 14 reads zero", v, 0);
    bus_read(15, v);
    check(v == 0, "R2", "unmapped addr 15 reads zero", v, 0);
    for (int c = 0; c < NCH; c++) begin
      bus_read(c, v);
      check(v == c * 17 + 1, "R2", $sformatf("ch%0d untouched by unmapped write", c),
            v, c * 17 + 1);
    end
  endtask

  task automatic t_compare;
    duty_check(3, 8'h01, 1024, 1 * DIV, "R3");
    duty_check(3, 8'h40, 1024, 64 * DIV, "R3");
    duty_check(3, 8'hC5, 1024, 197 * DIV, "R3");
  endtask

  task automatic t_zero;
    step253 = 1'b0;
    duty_check(4, 8'h00, 1024, 0, "R4");
    step253 = 1'b1;
    duty_check(4, 8'h00, 1012, 0, "R4");
    step253 = 1'b0;
  endtask

  task automatic t_short;
    int p;
    step253 = 1'b1;
    bus_write(6, 8'h80);
    wait_clks(2048);
    period_of(6, p);
    check(p == 253 * DIV, "R5", "253-step period clocks", p, 253 * DIV);
    duty_check(6, 8'hFC, 1012, 252 * DIV, "R5");
    duty_check(6, 8'hFD, 1012, 1012, "R5");
    duty_check(6, 8'hFE, 1012, 1012, "R5");
    duty_check(6, 8'hFF, 1012, 1012, "R5");
    step253 = 1'b0;
  endtask

  task automatic t_long;
    int p;
    step253 = 1'b0;
    bus_write(8, 8'h80);
    wait_clks(2048);
    period_of(8, p);
    check(p == 256 * DIV, "R6", "256-step period clocks", p, 256 * DIV);
    duty_check(8, 8'hFF, 1024, 255 * DIV, "R6");
  endtask

  task automatic t_freq;
    int p;
    bus_write(9, 8'h80);
    freq_fast = 1'b1;
    step253 = 1'b0;
    wait_clks(2048);
    period_of(9, p);
    check(p == 256 * DIV / 2, "R7", "fast 256-step period", p, 256 * DIV / 2);
    step253 = 1'b1;
    wait_clks(1024);
    period_of(9, p);
    check(p == 253 * DIV / 2, "R7", "fast 253-step period", p, 253 * DIV / 2);
    freq_fast = 1'b0;
    wait_clks(2048);
    period_of(9, p);
    check(p == 253 * DIV, "R7", "slow 253-step period", p, 253 * DIV);
    step253 = 1'b0;
    wait_clks(2048);
  endtask

  task automatic t_defer;
    int v;
    int lows;
    int hi;
    bus_write(5, 8'h80);
    wait_clks(2048);
    @(negedge clk);
    while (pwm_out[5]) @(negedge clk);
    while (!pwm_out[5]) @(negedge clk);
    wait_clks(8);
    bus_write(5, 8'h01);
    bus_read(5, v);
    check(v == 8'h01, "R8", "new code reads back at once", v, 8'h01);
    lows = 0;
    repeat (40) begin
      @(negedge clk);
      if (!pwm_out[5]) lows++;
    end
    check(lows == 0, "R8", "pulse in progress keeps old width (low clocks)", lows, 0);
    wait_clks(2048);
    high_count(5, 1024, hi);
    check(hi == 1 * DIV, "R8", "new code used after boundary", hi, 1 * DIV);
  endtask

  task automatic t_indep;
    int h0;
    int h13;
    int v;
    bus_write(0, 8'h10);
    bus_write(13, 8'hF0);
    bus_write(2, 8'h33);
    wait_clks(2048);
    high_count(0, 1024, h0);
    check(h0 == 16 * DIV, "R9", "ch0 width", h0, 16 * DIV);
    high_count(13, 1024, h13);
    check(h13 == 240 * DIV, "R9", "ch13 width", h13, 240 * DIV);
    bus_write(13, 8'h02);
    wait_clks(2048);
    high_count(0, 1024, h0);
    check(h0 == 16 * DIV, "R9", "ch0 unchanged after ch13 write", h0, 16 * DIV);
    bus_read(2, v);
    check(v == 8'h33, "R9", "ch2 readback unchanged", v, 8'h33);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(4);
    t_reset();
    t_bus();
    t_compare();
    t_zero();
    t_short();
    t_long();
    t_freq();
    t_defer();
    t_indep();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule